// File: doc/BRIEF.md
# Event Timer Register File and Main Counter

This block is the software-visible front end of a multi-channel event timer. It holds a free-running 64-bit main counter, a read-only capability word, a global configuration word and a window of per-channel registers. Each channel has a configuration word, a comparator and a message route. Software reaches every 64-bit value as two 32-bit words on a simple register bus. A read enable returns data on the next cycle. A write enable takes effect at the clock edge where it is sampled.

The block does not compare or deliver interrupts. It drives the run state, the counter, each channel's registers and a pair of one-cycle pulses per channel: arm and disarm. The comparison logic downstream uses these signals. The counter counts input ticks only while the global run bit is set. When run is cleared, the counter freezes and software may load it half by half. Turning run on arms every channel that holds a programmed comparator. Turning it off disarms every channel.

Top module: `evt_regfile`

## Requirements
- R1: After reset, the counter and global configuration read 0. Each channel configuration low word reads 0x30 (bit 4 periodic-capable, bit 5 wide-capable). Its high word reads the route-capability mask (default 0x0000FF00). Both comparator words read 0xFFFFFFFF. No arm or disarm pulse is active.
- R2: The capability low word at 0x000 reads {vendor id[31:16], bit 15 legacy-route capable = 1, bit 14 = 0, bit 13 wide counter = 1, bits 12:8 channel count minus one, revision[7:0]}. With defaults this is 0x0E7AA201. The high word at 0x004 reads the tick period in femtoseconds (default 10,000,000). Writes to either word have no effect. The channel count is the parameter clamped to the range 3..24.
- R3: Accesses are 32-bit words. A 64-bit register's low half sits at +0 and its high half at +4. Read data appears on rdata_o in the cycle after re_i is sampled.
- R4: The counter at 0x0F0/0x0F4 advances by exactly one on each cycle where run is set and tick_i is high, carrying across the halves. While run is clear, it holds its value.
- R5: While run is clear, a write to 0x0F0 or 0x0F4 loads that half only. While run is set, counter writes are ignored.
- R6: The global configuration at 0x010 has bit 0 = run and bit 1 = legacy route. All other bits read 0 and ignore writes. The word at 0x014 reads 0.
- R7: A write that takes run from 0 to 1 raises ch_arm_o for one cycle after the write edge. It does this for every channel whose comparator is not all ones, whatever that channel's enable bit.
- R8: A write that takes run from 1 to 0 raises ch_disarm_o for every implemented channel, for one cycle after the write edge.
- R9: A channel config write that takes its enable (bit 2) from 0 to 1 arms that channel, but only while run is set. A write taking enable from 1 to 0 disarms it.
- R10: Channel windows start at 0x100 with stride 0x20: config at +0x00, comparator at +0x08, route at +0x10. In the config low word, only mask 0x00007F4E is writable. The config high word is read-only. Comparator and route halves are fully writable.
- R11: Channel slots at or beyond the channel count read 0 and ignore writes. The status words at 0x020/0x024, unused channel offsets and undecoded addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 10 | Byte address of the 32-bit word |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data, valid the cycle after re_i |
| tick_i | input | 1 | Counter tick enable |
| counter_o | output | 64 | Main counter value |
| run_o | output | 1 | Global run bit |
| legacy_o | output | 1 | Global legacy-route bit |
| ch_cfg_o | output | NCH x 64 | Per-channel configuration |
| ch_cmp_o | output | NCH x 64 | Per-channel comparator |
| ch_route_o | output | NCH x 64 | Per-channel message route |
| ch_arm_o | output | NCH | One-cycle arm pulse per channel |
| ch_disarm_o | output | NCH | One-cycle disarm pulse per channel |

## Verification
The bound checker watches several rules on every cycle:
- the counter steps by one under tick while running and holds while stopped and unwritten;
- a run rise produces arm pulses that match exactly the channels with a programmed comparator;
- a run fall disarms all channels;
- arm never appears while stopped, and arm and disarm never overlap;
- the period word always reads back correctly.

Only the bench scenarios can show the rest:
- the writable masks and read-only fields;
- counter loads being accepted while stopped and dropped while running;
- channel enable edges under both run states;
- the silence of out-of-range channel slots.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int ADDR_W    = 10;
  localparam int CH_SLOTS  = 24;  // 0x100..0x3FF at stride 0x20
  localparam int CH_SH     = 5;

  localparam logic [ADDR_W-1:0] A_CAP_LO = 10'h000;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 10'h004;
  localparam logic [ADDR_W-1:0] A_CFG_LO = 10'h010;
  localparam logic [ADDR_W-1:0] A_CFG_HI = 10'h014;
  localparam logic [ADDR_W-1:0] A_STS_LO = 10'h020;
  localparam logic [ADDR_W-1:0] A_STS_HI = 10'h024;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 10'h0F0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 10'h0F4;
  localparam logic [4:0]        CH_FIRST = 5'd8;   // 0x100 >> CH_SH

  localparam int RUN_BIT = 0;
  localparam int LEG_BIT = 1;
  localparam int CH_EN_BIT = 2;
  localparam logic [31:0] CH_RO_CAPS = 32'h0000_0030;
  localparam logic [31:0] CH_WMASK   = 32'h0000_7F4E;

  typedef enum logic [3:0] {
    G_CAP_LO, G_CAP_HI, G_CFG_LO, G_CFG_HI,
    G_STS_LO, G_STS_HI, G_CNT_LO, G_CNT_HI, G_NONE
  } glb_sel_e;

  typedef enum logic [2:0] {
    S_CFG_LO, S_CFG_HI, S_CMP_LO, S_CMP_HI,
    S_RT_LO, S_RT_HI, S_RSV6, S_RSV7
  } ch_sub_e;
endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
  import evt_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output glb_sel_e          gsel_o,
  output logic              ch_hit_o,
  output logic [4:0]        ch_idx_o,
  output ch_sub_e           sub_o
);
  logic in_chan;

  assign in_chan  = (addr_i[ADDR_W-1 -: 2] != 2'b00);
  assign ch_idx_o = addr_i[ADDR_W-1:CH_SH] - CH_FIRST;
  assign ch_hit_o = in_chan && (ch_idx_o < 5'(NCH));
  assign sub_o    = ch_sub_e'(addr_i[4:2]);

  always_comb begin
    gsel_o = G_NONE;
    if (!in_chan) begin
      unique case ({addr_i[ADDR_W-1:2], 2'b00})
        A_CAP_LO: gsel_o = G_CAP_LO;
        A_CAP_HI: gsel_o = G_CAP_HI;
        A_CFG_LO: gsel_o = G_CFG_LO;
        A_CFG_HI: gsel_o = G_CFG_HI;
        A_STS_LO: gsel_o = G_STS_LO;
        A_STS_HI: gsel_o = G_STS_HI;
        A_CNT_LO: gsel_o = G_CNT_LO;
        A_CNT_HI: gsel_o = G_CNT_HI;
        default:  gsel_o = G_NONE;
      endcase
    end
  end
endmodule

// File: rtl/evt_counter.sv
module evt_counter (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        tick_i,
  input  logic        ld_lo_i,
  input  logic        ld_hi_i,
  input  logic [31:0] wdata_i,
  output logic [63:0] cnt_o
);
  logic [63:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (run_i) begin
      if (tick_i) cnt_q <= cnt_q + 64'd1;
    end else if (ld_lo_i) begin
      cnt_q[31:0] <= wdata_i;
    end else if (ld_hi_i) begin
      cnt_q[63:32] <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_chan_regs.sv
module evt_chan_regs
  import evt_pkg::*;
#(
  parameter logic [31:0] ROUTE_CAP = 32'h0000_FF00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  ch_sub_e     sub_i,
  input  logic [31:0] wdata_i,
  input  logic        run_i,
  input  logic        glb_rise_i,
  input  logic        glb_fall_i,
  output logic [63:0] cfg_o,
  output logic [63:0] cmp_o,
  output logic [63:0] route_o,
  output logic        arm_o,
  output logic        disarm_o
);
  logic [31:0] cfg_lo_q;
  logic [63:0] cmp_q, route_q;
  logic        arm_q, dis_q;
  logic        cfg_wr, en_old, en_new, cmp_live;

  assign cfg_wr   = wr_i && (sub_i == S_CFG_LO);
  assign en_old   = cfg_lo_q[CH_EN_BIT];
  assign en_new   = wdata_i[CH_EN_BIT];
  assign cmp_live = ~&cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_lo_q <= CH_RO_CAPS;
      cmp_q    <= '1;
      route_q  <= '0;
      arm_q    <= 1'b0;
      dis_q    <= 1'b0;
    end else begin
      arm_q <= (glb_rise_i && cmp_live) || (cfg_wr && !en_old && en_new && run_i);
      dis_q <= glb_fall_i || (cfg_wr && en_old && !en_new);
      if (wr_i) begin
        unique case (sub_i)
          S_CFG_LO: cfg_lo_q <= (wdata_i & CH_WMASK) | (cfg_lo_q & ~CH_WMASK);
          S_CMP_LO: cmp_q[31:0]    <= wdata_i;
          S_CMP_HI: cmp_q[63:32]   <= wdata_i;
          S_RT_LO:  route_q[31:0]  <= wdata_i;
          S_RT_HI:  route_q[63:32] <= wdata_i;
          default:  ;
        endcase
      end
    end
  end

  assign cfg_o    = {ROUTE_CAP, cfg_lo_q};
  assign cmp_o    = cmp_q;
  assign route_o  = route_q;
  assign arm_o    = arm_q;
  assign disarm_o = dis_q;
endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
  import evt_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter int          MIN_CH    = 3,
  parameter int          MAX_CH    = 24,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000,
  parameter logic [15:0] VENDOR_ID = 16'h0E7A,
  parameter logic [7:0]  REV_ID    = 8'h01,
  parameter logic [31:0] ROUTE_CAP = 32'h0000_FF00,
  localparam int         HI_CH     = (MAX_CH > CH_SLOTS) ? CH_SLOTS : MAX_CH,
  localparam int         NCH       = (NUM_CH < MIN_CH) ? MIN_CH :
                                     (NUM_CH > HI_CH) ? HI_CH : NUM_CH
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     we_i,
  input  logic [31:0]              wdata_i,
  input  logic                     re_i,
  output logic [31:0]              rdata_o,
  input  logic                     tick_i,
  output logic [63:0]              counter_o,
  output logic                     run_o,
  output logic                     legacy_o,
  output logic [NCH-1:0][63:0]     ch_cfg_o,
  output logic [NCH-1:0][63:0]     ch_cmp_o,
  output logic [NCH-1:0][63:0]     ch_route_o,
  output logic [NCH-1:0]           ch_arm_o,
  output logic [NCH-1:0]           ch_disarm_o
);
  glb_sel_e    gsel;
  ch_sub_e     sub;
  logic        ch_hit;
  logic [4:0]  ch_idx;
  logic [1:0]  gcfg_q;
  logic        gcfg_wr, glb_rise, glb_fall;
  logic [63:0] cnt;
  logic [31:0] cap_lo, rd_mux, ch_word;
  logic [31:0] rdata_q;

  evt_addr_dec #(.NCH(NCH)) u_dec (
    .addr_i   (addr_i),
    .gsel_o   (gsel),
    .ch_hit_o (ch_hit),
    .ch_idx_o (ch_idx),
    .sub_o    (sub)
  );

  assign gcfg_wr  = we_i && (gsel == G_CFG_LO);
  assign glb_rise = gcfg_wr &&  wdata_i[RUN_BIT] && !gcfg_q[RUN_BIT];
  assign glb_fall = gcfg_wr && !wdata_i[RUN_BIT] &&  gcfg_q[RUN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gcfg_q <= '0;
    else if (gcfg_wr) gcfg_q <= {wdata_i[LEG_BIT], wdata_i[RUN_BIT]};
  end

  assign run_o    = gcfg_q[RUN_BIT];
  assign legacy_o = gcfg_q[LEG_BIT];

  evt_counter u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (gcfg_q[RUN_BIT]),
    .tick_i  (tick_i),
    .ld_lo_i (we_i && (gsel == G_CNT_LO)),
    .ld_hi_i (we_i && (gsel == G_CNT_HI)),
    .wdata_i (wdata_i),
    .cnt_o   (cnt)
  );
  assign counter_o = cnt;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    evt_chan_regs #(.ROUTE_CAP(ROUTE_CAP)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (we_i && ch_hit && (ch_idx == 5'(g))),
      .sub_i      (sub),
      .wdata_i    (wdata_i),
      .run_i      (gcfg_q[RUN_BIT]),
      .glb_rise_i (glb_rise),
      .glb_fall_i (glb_fall),
      .cfg_o      (ch_cfg_o[g]),
      .cmp_o      (ch_cmp_o[g]),
      .route_o    (ch_route_o[g]),
      .arm_o      (ch_arm_o[g]),
      .disarm_o   (ch_disarm_o[g])
    );
  end

  assign cap_lo = {VENDOR_ID, 1'b1, 1'b0, 1'b1, 5'(NCH - 1), REV_ID};

  always_comb begin
    ch_word = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_idx == 5'(i)) begin
        unique case (sub)
          S_CFG_LO: ch_word = ch_cfg_o[i][31:0];
          S_CFG_HI: ch_word = ch_cfg_o[i][63:32];
          S_CMP_LO: ch_word = ch_cmp_o[i][31:0];
          S_CMP_HI: ch_word = ch_cmp_o[i][63:32];
          S_RT_LO:  ch_word = ch_route_o[i][31:0];
          S_RT_HI:  ch_word = ch_route_o[i][63:32];
          default:  ch_word = '0;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (ch_hit) begin
      rd_mux = ch_word;
    end else begin
      unique case (gsel)
        G_CAP_LO: rd_mux = cap_lo;
        G_CAP_HI: rd_mux = PERIOD_FS;
        G_CFG_LO: rd_mux = {30'd0, gcfg_q};
        G_CNT_LO: rd_mux = cnt[31:0];
        G_CNT_HI: rd_mux = cnt[63:32];
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/evt_regfile_chk.sv
module evt_regfile_chk #(
  parameter int          NCH       = 3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [9:0]           addr_i,
  input logic                 we_i,
  input logic                 re_i,
  input logic [31:0]          rdata_o,
  input logic                 tick_i,
  input logic [63:0]          counter_o,
  input logic                 run_o,
  input logic [NCH-1:0][63:0] ch_cmp_o,
  input logic [NCH-1:0]       ch_arm_o,
  input logic [NCH-1:0]       ch_disarm_o
);
  logic [NCH-1:0] cmp_live;
  always_comb
    for (int i = 0; i < NCH; i++) cmp_live[i] = (ch_cmp_o[i] != '1);

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && tick_i) |=> (counter_o == $past(counter_o) + 64'd1));

  p_cnt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !we_i) |=> $stable(counter_o));

  p_period_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 10'h004) |=> (rdata_o == PERIOD_FS));

  p_run_only_by_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(run_o));

  p_rise_arms_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> (ch_arm_o == $past(cmp_live)));

  p_fall_disarms_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> (&ch_disarm_o));

  p_arm_needs_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_arm_o != '0) |-> run_o);

  p_arm_disarm_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ch_arm_o & ch_disarm_o) == '0));
endmodule

bind evt_regfile evt_regfile_chk #(.NCH(NCH), .PERIOD_FS(PERIOD_FS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .re_i        (re_i),
  .rdata_o     (rdata_o),
  .tick_i      (tick_i),
  .counter_o   (counter_o),
  .run_o       (run_o),
  .ch_cmp_o    (ch_cmp_o),
  .ch_arm_o    (ch_arm_o),
  .ch_disarm_o (ch_disarm_o)
);

// File: tb/sim_evt_regfile.sv
`timescale 1ns/1ps
module sim_evt_regfile;
  localparam int N = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [9:0]        addr = '0;
  logic              we = 1'b0;
  logic [31:0]       wdata = '0;
  logic              re = 1'b0;
  logic [31:0]       rdata;
  logic              tick = 1'b0;
  logic [63:0]       counter;
  logic              run, legacy;
  logic [N-1:0][63:0] cfg, cmp, route;
  logic [N-1:0]      arm, disarm;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [5:0]  pl_exp_q[$];
  string       pl_tag_q[$];

  always #4 clk = ~clk;

  evt_regfile u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .tick_i(tick), .counter_o(counter),
    .run_o(run), .legacy_o(legacy), .ch_cfg_o(cfg), .ch_cmp_o(cmp),
    .ch_route_o(route), .ch_arm_o(arm), .ch_disarm_o(disarm)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a; re = 1'b1;
    rd_exp_q.push_back(e); rd_tag_q.push_back(tag);
    @(negedge clk);
    re = 1'b0;
  endtask

  // expected pulses: {arm, disarm} seen in the cycle after the write edge
  task automatic wr(input logic [9:0] a, input logic [31:0] d,
                    input logic [2:0] e_arm, input logic [2:0] e_dis, input string tag);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    pl_exp_q.push_back({e_arm, e_dis}); pl_tag_q.push_back(tag);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  // monitor: scoreboard pops
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (re && rd_exp_q.size() > 0)
        chk(rd_tag_q.pop_front(), {32'd0, rdata}, {32'd0, rd_exp_q.pop_front()});
      if (we && pl_exp_q.size() > 0)
        chk(pl_tag_q.pop_front(), {58'd0, arm, disarm}, {58'd0, pl_exp_q.pop_front()});
    end
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R3 watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulses idle", {58'd0, arm, disarm}, 64'd0);
    chk("R1 rdata idle", {32'd0, rdata}, 64'd0);

    rd(10'h000, 32'h0E7A_A201, "R2 cap lo");
    rd(10'h004, 32'd10_000_000, "R2 cap hi period");
    rd(10'h010, 32'h0, "R1 gcfg");
    rd(10'h0F0, 32'h0, "R1 cnt lo");
    rd(10'h0F4, 32'h0, "R1 cnt hi");
    rd(10'h100, 32'h30, "R1 ch0 cfg lo");
    rd(10'h104, 32'h0000_FF00, "R1 ch0 cfg hi");
    rd(10'h148, 32'hFFFF_FFFF, "R1 ch2 cmp lo");
    rd(10'h12C, 32'hFFFF_FFFF, "R1 ch1 cmp hi");

    wr(10'h000, 32'h1234_5678, 3'b000, 3'b000, "R2 cap write pulses");
    wr(10'h004, 32'h0, 3'b000, 3'b000, "R2 cap hi write pulses");
    rd(10'h000, 32'h0E7A_A201, "R2 cap lo after write");
    rd(10'h004, 32'd10_000_000, "R2 cap hi after write");

    wr(10'h010, 32'hFFFF_FFFC, 3'b000, 3'b000, "R6 gcfg masked write");
    rd(10'h010, 32'h0, "R6 gcfg unwritable bits");
    wr(10'h010, 32'h2, 3'b000, 3'b000, "R6 legacy only");
    rd(10'h010, 32'h2, "R6 legacy readback");
    chk("R6 legacy port", {63'd0, legacy}, 64'd1);
    wr(10'h014, 32'hFFFF_FFFF, 3'b000, 3'b000, "R6 gcfg hi write");
    rd(10'h014, 32'h0, "R6 gcfg hi reads zero");

    wr(10'h0F0, 32'hFFFF_FFFE, 3'b000, 3'b000, "R5 cnt lo load");
    wr(10'h0F4, 32'h1, 3'b000, 3'b000, "R5 cnt hi load");
    rd(10'h0F0, 32'hFFFF_FFFE, "R5 cnt lo loaded");
    rd(10'h0F4, 32'h1, "R5 cnt hi loaded");
    ticks(4);
    rd(10'h0F0, 32'hFFFF_FFFE, "R4 frozen while stopped");

    wr(10'h128, 32'h100, 3'b000, 3'b000, "R10 ch1 cmp lo");
    wr(10'h12C, 32'h0, 3'b000, 3'b000, "R10 ch1 cmp hi");
    rd(10'h128, 32'h100, "R10 ch1 cmp lo rb");
    rd(10'h12C, 32'h0, "R10 ch1 cmp hi rb");
    wr(10'h150, 32'hDEAD_BEEF, 3'b000, 3'b000, "R10 ch2 route lo");
    rd(10'h150, 32'hDEAD_BEEF, "R10 ch2 route rb");

    wr(10'h120, 32'h4, 3'b000, 3'b000, "R9 ch1 enable while stopped no arm");
    rd(10'h120, 32'h34, "R10 ch1 cfg lo");

    wr(10'h010, 32'h3, 3'b010, 3'b000, "R7 run rise arms programmed ch");
    chk("R7 run port", {63'd0, run}, 64'd1);
    ticks(5);
    rd(10'h0F0, 32'h3, "R4 cnt lo after carry");
    rd(10'h0F4, 32'h2, "R4 cnt hi after carry");
    wr(10'h0F0, 32'h0, 3'b000, 3'b000, "R5 load while running");
    rd(10'h0F0, 32'h3, "R5 load ignored while running");

    wr(10'h100, 32'h4, 3'b001, 3'b000, "R9 ch0 enable rise arms");
    wr(10'h100, 32'h0, 3'b000, 3'b001, "R9 ch0 enable fall disarms");
    wr(10'h140, 32'hFFFF_FFFF, 3'b100, 3'b000, "R9 ch2 enable rise arms");
    rd(10'h140, 32'h7F7E, "R10 ch2 cfg mask");
    wr(10'h144, 32'h0, 3'b000, 3'b000, "R10 ch2 cfg hi write");
    rd(10'h144, 32'h0000_FF00, "R10 ch2 cfg hi read-only");

    wr(10'h010, 32'h0, 3'b000, 3'b111, "R8 run fall disarms all");
    ticks(3);
    rd(10'h0F0, 32'h3, "R4 frozen after stop");

    wr(10'h160, 32'h4, 3'b000, 3'b000, "R11 ch3 write");
    rd(10'h160, 32'h0, "R11 ch3 reads zero");
    wr(10'h168, 32'h55, 3'b000, 3'b000, "R11 ch3 cmp write");
    rd(10'h168, 32'h0, "R11 ch3 cmp zero");
    rd(10'h3E4, 32'h0, "R11 last slot zero");
    rd(10'h020, 32'h0, "R11 status zero");
    rd(10'h118, 32'h0, "R11 unused ch offset");
    rd(10'h108, 32'hFFFF_FFFF, "R11 ch0 cmp untouched");

    wr(10'h010, 32'h1, 3'b010, 3'b000, "R7 rerun arms only live cmp");
    wr(10'h130, 32'h1, 3'b000, 3'b000, "R10 route write no pulse");
    rd(10'h010, 32'h1, "R6 run readback");

    repeat (3) @(negedge clk);
    chk("R3 scoreboard drained", 64'(rd_exp_q.size() + pl_exp_q.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule